// File: doc/BRIEF.md
# Dual Reload Timer with Toggle Output

The block holds two independent 16-bit down-counters. Each one steps down once per pulse on its own tick input, which is the already-selected clock event from outside the block. When a counter that holds zero receives a tick, it takes the value of its own reload register instead of wrapping. This makes the underflow period of each counter equal to its reload value plus one tick.

Counter 1 can drive an output pin that inverts on every underflow while the toggle enable is set. The pin then gives a square wave with a 50% duty cycle and needs no software action. Software sets the starting level of the pin by writing it directly. A rising edge of the pin that comes from a toggle sets the first pending flag. Every underflow of counter 2 sets the second pending flag. Each interrupt output is a registered copy of its pending flag ANDed with its enable.

Software reaches all state through a plain register port. A write is accepted in the cycle that presents it, so the port has no back-pressure and no handshake. Reads are combinational from the address. The offsets are: 0 reload A, 1 reload B, 2 counter 1, 3 counter 2, 4 control, 5 pin level, 6 pending. In the control register, bit 0 is the toggle enable, bit 1 is the interrupt 1 enable and bit 2 is the interrupt 2 enable. In the pending register, bit 0 is pending 1 and bit 1 is pending 2.

Top module: `dual_reload_timer`

## Requirements
- R1: A counter decrements by one on each cycle that its tick input is high, and holds its value on every other cycle.
- R2: When counter 1 holds 0 and receives a tick, it loads reload A (offset 0) on that edge instead of wrapping to 0xFFFF.
- R3: When counter 2 holds 0 and receives a tick, it loads reload B (offset 1) on that edge.
- R4: The pin inverts on each counter 1 underflow only while control bit 0 is 1. Otherwise the pin keeps its level.
- R5: A write to offset 5 loads bit 0 into the pin on the next edge. That write never sets pending 1, even when it raises the pin from 0 to 1.
- R6: A toggle that takes the pin from 0 to 1 sets pending bit 0 on the same edge. The irq1 output equals pending 1 AND control bit 1, delayed by one cycle.
- R7: Every counter 2 underflow sets pending bit 1. The irq2 output equals pending 2 AND control bit 2, delayed by one cycle.
- R8: Writing 1 to a bit of offset 6 clears that pending bit. A set event in the same cycle as the clear leaves the bit set.
- R9: After reset, the counters, the reload registers, the control register, the pending bits, the pin and both interrupts are all 0.
- R10: A write to offset 2 or offset 3 loads that counter, and it takes priority over a tick in the same cycle. Such a load does not count as an underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick1 | input | 1 | Count pulse for counter 1 |
| tick2 | input | 1 | Count pulse for counter 2 |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register offset for reads and writes |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Combinational read data at addr |
| pin_out | output | 1 | Toggle output pin |
| irq1 | output | 1 | Counter 1 interrupt |
| irq2 | output | 1 | Counter 2 interrupt |

## Verification
On every cycle, the assertions check the counter step rules: decrement, hold, reload on underflow, and the priority of a write over a tick. They also check pin holding and inversion, the stickiness of the pending bits, the rule that an interrupt stays low while its enable is off, and the rule that pending 1 can only rise together with a rise of the pin. Only the bench scenarios can show the full behaviour over time. These scenarios sweep reload values from 0 upward and compare each counter value, pin level and pending bit against an arithmetic model after every tick. They also show that a software write that raises the pin leaves pending 1 clear, and that a clear arriving in the same cycle as an underflow leaves the flag set.

// File: rtl/drt_pkg.sv
package drt_pkg;
  localparam int REG_AW = 3;
  typedef enum logic [REG_AW-1:0] {
    REG_RLD_A = 3'd0,
    REG_RLD_B = 3'd1,
    REG_CNT1  = 3'd2,
    REG_CNT2  = 3'd3,
    REG_CTRL  = 3'd4,
    REG_PIN   = 3'd5,
    REG_PEND  = 3'd6
  } reg_addr_e;
  localparam int CTRL_TOG = 0;
  localparam int CTRL_IE1 = 1;
  localparam int CTRL_IE2 = 2;
  localparam int CTRL_W   = 3;
endpackage

// File: rtl/drt_counter.sv
module drt_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] reload,
  output logic [W-1:0] cnt,
  output logic         underflow
);
  localparam logic [W-1:0] ZERO = '0;

  assign underflow = tick && !load && (cnt == ZERO);

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt <= ZERO;
    else if (load)      cnt <= load_val;
    else if (underflow) cnt <= reload;
    else if (tick)      cnt <= cnt - 1'b1;
  end

  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && cnt != ZERO) |=> cnt == $past(cnt) - 1'b1); // R1
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt)); // R1
  AST_RELOAD_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && cnt == ZERO) |=> cnt == $past(reload)); // R2
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt == $past(load_val)); // R10
endmodule

// File: rtl/drt_pin.sv
module drt_pin (
  input  logic clk,
  input  logic rst_n,
  input  logic underflow,
  input  logic toggle_en,
  input  logic lvl_wr,
  input  logic lvl_val,
  output logic pin,
  output logic rise
);
  logic flip;
  assign flip = underflow && toggle_en && !lvl_wr;
  assign rise = flip && !pin;

  always_ff @(posedge clk) begin
    if (!rst_n)      pin <= 1'b0;
    else if (lvl_wr) pin <= lvl_val;
    else if (flip)   pin <= ~pin;
  end

  AST_PIN_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && toggle_en && !lvl_wr) |=> pin != $past(pin)); // R4
  AST_PIN_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl_wr && !(underflow && toggle_en)) |=> $stable(pin)); // R4
  AST_PIN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_wr |=> pin == $past(lvl_val)); // R5
endmodule

// File: rtl/drt_pending.sv
module drt_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic en,
  output logic pend,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      irq  <= 1'b0;
    end else begin
      pend <= (pend && !clr) || set;
      irq  <= pend && en;
    end
  end

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !clr) |=> pend); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> pend); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !irq); // R6
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer #(
  parameter int CNT_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tick1,
  input  logic                        tick2,
  input  logic                        wr_en,
  input  logic [drt_pkg::REG_AW-1:0]  addr,
  input  logic [CNT_W-1:0]            wr_data,
  output logic [CNT_W-1:0]            rd_data,
  output logic                        pin_out,
  output logic                        irq1,
  output logic                        irq2
);
  import drt_pkg::*;

  localparam int NCH = 2;

  logic [CNT_W-1:0]  rld_a, rld_b;
  logic [CTRL_W-1:0] ctrl;
  logic [CNT_W-1:0]  cnt    [NCH];
  logic [CNT_W-1:0]  rld    [NCH];
  logic [NCH-1:0]    tick, load, uf, pend, pset, ien, irq;
  logic              pin_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rld_a <= '0;
      rld_b <= '0;
      ctrl  <= '0;
    end else if (wr_en) begin
      if (addr == REG_RLD_A) rld_a <= wr_data;
      if (addr == REG_RLD_B) rld_b <= wr_data;
      if (addr == REG_CTRL)  ctrl  <= wr_data[CTRL_W-1:0];
    end
  end

  assign tick = {tick2, tick1};
  assign load = {wr_en && addr == REG_CNT2, wr_en && addr == REG_CNT1};
  assign rld[0] = rld_a;
  assign rld[1] = rld_b;
  assign ien  = {ctrl[CTRL_IE2], ctrl[CTRL_IE1]};
  assign pset = {uf[1], pin_rise};

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    drt_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick[i]), .load(load[i]),
      .load_val(wr_data), .reload(rld[i]), .cnt(cnt[i]), .underflow(uf[i])
    );
    drt_pending u_pend (
      .clk(clk), .rst_n(rst_n), .set(pset[i]),
      .clr(wr_en && addr == REG_PEND && wr_data[i]),
      .en(ien[i]), .pend(pend[i]), .irq(irq[i])
    );
  end

  drt_pin u_pin (
    .clk(clk), .rst_n(rst_n), .underflow(uf[0]), .toggle_en(ctrl[CTRL_TOG]),
    .lvl_wr(wr_en && addr == REG_PIN), .lvl_val(wr_data[0]),
    .pin(pin_out), .rise(pin_rise)
  );

  assign irq1 = irq[0];
  assign irq2 = irq[1];

  always_comb begin
    rd_data = '0;
    case (addr)
      REG_RLD_A: rd_data = rld_a;
      REG_RLD_B: rd_data = rld_b;
      REG_CNT1:  rd_data = cnt[0];
      REG_CNT2:  rd_data = cnt[1];
      REG_CTRL:  rd_data[CTRL_W-1:0] = ctrl;
      REG_PIN:   rd_data[0] = pin_out;
      REG_PEND:  rd_data[NCH-1:0] = pend;
      default:   rd_data = '0;
    endcase
  end

  AST_PEND1_FROM_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend[0]) |-> $rose(pin_out)); // R6
  AST_PEND2_ON_UF: assert property (@(posedge clk) disable iff (!rst_n)
    uf[1] |=> pend[1]); // R7
  AST_CNT2_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    uf[1] |=> cnt[1] == $past(rld_b)); // R3
endmodule

// File: tb/dual_reload_timer_test.sv
`timescale 1ns/1ps
module dual_reload_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick1 = 1'b0, tick2 = 1'b0, wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        pin_out, irq1, irq2;
  int n_tests = 0, n_fail = 0;

  always #2 clk = ~clk;

  dual_reload_timer uut (
    .clk(clk), .rst_n(rst_n), .tick1(tick1), .tick2(tick2), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .pin_out(pin_out),
    .irq1(irq1), .irq2(irq2)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic [2:0] a, input logic [15:0] d,
                     input logic t1, input logic t2);
    @(negedge clk);
    wr_en = w; addr = a; wr_data = d; tick1 = t1; tick2 = t2;
    @(negedge clk);
    wr_en = 1'b0; tick1 = 1'b0; tick2 = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    addr = a;
    #0.5;
    v = rd_data;
  endtask

  initial begin
    #(200000 * 4);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [15:0] m;
    logic        mp, uf;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      chk("R9 reg after reset", v, 16'h0);
    end
    chk("R9 pin", {15'b0, pin_out}, 16'h0);
    chk("R9 irqs", {14'b0, irq2, irq1}, 16'h0);

    // R1 R3 R7: counter 2 sweep over reload values
    cyc(1, 3'd4, 16'h4, 0, 0);
    for (int rl = 0; rl < 5; rl++) begin
      cyc(1, 3'd1, 16'(rl), 0, 0);
      cyc(1, 3'd3, 16'(rl), 0, 0);
      m = 16'(rl);
      for (int k = 0; k < 2 * (rl + 1) + 1; k++) begin
        cyc(0, 3'd0, 16'h0, 0, 1);
        uf = (m == 0);
        m = uf ? 16'(rl) : m - 1'b1;
        rd(3'd3, v); chk("R1/R3 cnt2 step", v, m);
        rd(3'd6, v); chk("R7 pend2", {15'b0, v[1]}, {15'b0, uf});
        if (uf) begin
          @(negedge clk);
          chk("R7 irq2 follows pend2", {15'b0, irq2}, 16'h1);
          cyc(1, 3'd6, 16'h2, 0, 0);
        end
      end
    end

    // R2 R4 R6: counter 1 with toggle and irq1 enabled
    cyc(1, 3'd4, 16'h3, 0, 0);
    for (int rl = 0; rl < 4; rl++) begin
      cyc(1, 3'd0, 16'(rl), 0, 0);
      cyc(1, 3'd2, 16'(rl), 0, 0);
      cyc(1, 3'd5, 16'h0, 0, 0);
      cyc(1, 3'd6, 16'h3, 0, 0);
      m = 16'(rl); mp = 1'b0;
      for (int k = 0; k < 3 * (rl + 1) + 1; k++) begin
        cyc(0, 3'd0, 16'h0, 1, 0);
        uf = (m == 0);
        m = uf ? 16'(rl) : m - 1'b1;
        if (uf) mp = ~mp;
        rd(3'd2, v); chk("R2 cnt1 step", v, m);
        chk("R4 pin level", {15'b0, pin_out}, {15'b0, mp});
        rd(3'd6, v); chk("R6 pend1 on rise", {15'b0, v[0]}, {15'b0, uf && mp});
        if (uf && mp) begin
          @(negedge clk);
          chk("R6 irq1", {15'b0, irq1}, 16'h1);
          cyc(1, 3'd6, 16'h1, 0, 0);
        end
      end
    end

    // R4 toggle disabled: underflow leaves pin alone
    cyc(1, 3'd6, 16'h3, 0, 0);
    cyc(1, 3'd4, 16'h2, 0, 0);
    cyc(1, 3'd5, 16'h0, 0, 0);
    cyc(1, 3'd2, 16'h0, 0, 0);
    cyc(0, 3'd0, 16'h0, 1, 0);
    chk("R4 no toggle when disabled", {15'b0, pin_out}, 16'h0);
    rd(3'd6, v); chk("R4 no pend1 when disabled", v, 16'h0);

    // R5 pin write low->high does not set pending
    cyc(1, 3'd5, 16'h1, 0, 0);
    chk("R5 pin loaded", {15'b0, pin_out}, 16'h1);
    rd(3'd6, v); chk("R5 no pend from write", v, 16'h0);
    @(negedge clk);
    chk("R5 irq1 quiet", {15'b0, irq1}, 16'h0);

    // R8 set wins over clear; plain clear works
    cyc(1, 3'd1, 16'h3, 0, 0);
    cyc(1, 3'd3, 16'h0, 0, 0);
    cyc(1, 3'd6, 16'h2, 0, 1);
    rd(3'd6, v); chk("R8 set beats clear", {15'b0, v[1]}, 16'h1);
    cyc(1, 3'd6, 16'h2, 0, 0);
    rd(3'd6, v); chk("R8 clear", {15'b0, v[1]}, 16'h0);

    // R7 masked irq2
    cyc(1, 3'd4, 16'h0, 0, 0);
    cyc(1, 3'd3, 16'h0, 0, 0);
    cyc(0, 3'd0, 16'h0, 0, 1);
    @(negedge clk);
    rd(3'd6, v); chk("R7 pend2 set while masked", {15'b0, v[1]}, 16'h1);
    chk("R7 irq2 masked", {15'b0, irq2}, 16'h0);

    // R10 counter write beats tick
    cyc(1, 3'd2, 16'h7, 1, 0);
    rd(3'd2, v); chk("R10 write priority", v, 16'h7);
    cyc(1, 3'd3, 16'h0, 0, 1);
    rd(3'd3, v); chk("R10 load of zero no reload", v, 16'h0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule